// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block is the transmit half of an asynchronous serial port. Software writes words into a one-entry holding register. The block moves each word into a shift register as soon as the shifter is free, builds the frame and drives it onto the serial line, one bit per sixteen ticks. The ticks come from an external baud generator that runs at 16x oversampling. Two flags follow the buffering. `txEmpty` shows that the holding register may take another word. `txDone` shows that the line has gone quiet after the last stop bit.

The frame format is chosen at run time. Software picks 8 or 9 bit positions, can turn parity on, and picks one or two stop bits. When parity is on, the parity bit takes the top position of the selected word length, so the frame does not get longer. An interrupt request follows `txEmpty` whenever its enable is set. This lets a driver refill the buffer while the current word is still shifting.

Top module: `uart_tx_buffered`

## Requirements
- R1: After reset `txLine` is 1, `txEmpty` is 1 and `txDone` is 1.
- R2: A write (`wrEn` high) while `txEmpty` is 1 loads the holding register and clears both `txEmpty` and `txDone` at that clock edge.
- R3: A write while `txEmpty` is 0 is ignored: the word already held is the one that is later sent.
- R4: With both enables set and the shifter idle, the held word moves to the shifter on the edge after the write. At that edge `txEmpty` returns to 1 and the start bit begins. If the shifter is busy, the move happens on the edge that ends its last stop bit, with no idle gap between the frames.
- R5: A frame is one low start bit, then the bit positions LSB first, then high stop bits. Every bit lasts exactly 16 ticks.
- R6: `wordLong` = 0 sends 8 bit positions (`wrData[7:0]`). `wordLong` = 1 sends 9 (`wrData[8:0]`).
- R7: With `parityOn` = 1 the top bit position carries parity over the lower data positions instead of data. `parityOdd` = 0 makes the total count of ones even, and `parityOdd` = 1 makes it odd.
- R8: `stopSel` = 2'b10 gives two stop bits. 2'b00, and any other code, gives one.
- R9: `txDone` rises on the edge that ends the last stop bit, and only if the holding register is empty at that edge. Otherwise it stays 0 until a frame ends with nothing waiting.
- R10: While `enGlobal` or `enTx` is 0, `txLine` is 1 and no word is moved to the shifter. A held word waits with `txEmpty` at 0. Clearing an enable during a frame aborts the frame, and the line is high by the next clock.
- R11: `irq` equals `txEmpty` AND `txeIrqEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 16x oversampling strobe, one clock wide |
| wrEn | input | 1 | Write strobe for the holding register |
| wrData | input | 9 | Word to send |
| enGlobal | input | 1 | Port-wide enable |
| enTx | input | 1 | Transmitter enable |
| wordLong | input | 1 | 0: 8 bit positions, 1: 9 bit positions |
| parityOn | input | 1 | Parity replaces the top bit position |
| parityOdd | input | 1 | 0: even parity, 1: odd parity |
| stopSel | input | 2 | 2'b10: two stop bits, otherwise one |
| txeIrqEn | input | 1 | Interrupt enable for the empty flag |
| txLine | output | 1 | Serial output, idles high |
| txEmpty | output | 1 | Holding register empty |
| txDone | output | 1 | All frames fully shifted out |
| irq | output | 1 | Interrupt request |

## Verification
The flags are due one edge after a write (R2) and the start bit one edge after that (R4). The bench samples `txEmpty`, `txDone` and `txLine` on the falling edge after exactly those rising edges. With a tick on every clock, `txDone` must still be 0 after 16·L−1 further edges and must be 1 after 16·L, where L is the frame length in bits. The bench samples serial bits in the middle of each bit: it finds the falling start edge, waits 8 tick periods, then steps 16 tick periods per bit. A run with a tick every third clock shows that the bench tolerates a shortened first tick. Half a bit after the last stop bit, `txDone` must already be high. This checks the frame length and the stop count.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadHold;   // capture bus word into holding register
    logic loadShift;  // build frame from holding register
    logic shiftBit;   // advance to next serial bit
    logic busy;       // a frame is on the line
  } txStrobe_t;
endpackage

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 9
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      wrEn,
  input  logic      txEnable,
  input  logic      wordLong,
  input  logic      stopTwo,
  output logic      txEmpty,
  output logic      txDone,
  output txStrobe_t strobe
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int TICK_W  = $clog2(OVERSAMPLE);
  localparam int IDX_W   = $clog2(FRAME_W + 1);

  logic              holdFull;
  logic              busy;
  logic              doneFlag;
  logic [TICK_W-1:0] tickCnt;
  logic [IDX_W-1:0]  bitIdx;
  logic [IDX_W-1:0]  frameLen;
  logic [IDX_W-1:0]  nextLen;
  logic              acceptWr;
  logic              bitEnd;
  logic              lastTick;
  logic              loadShift;

  assign nextLen   = IDX_W'(1 + (wordLong ? DATA_W : DATA_W - 1) + (stopTwo ? 2 : 1));
  assign acceptWr  = wrEn && !holdFull;
  assign bitEnd    = busy && tick && (tickCnt == TICK_W'(OVERSAMPLE - 1));
  assign lastTick  = bitEnd && (bitIdx == frameLen - IDX_W'(1));
  assign loadShift = txEnable && holdFull && (!busy || lastTick);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      busy     <= 1'b0;
      doneFlag <= 1'b1;
      tickCnt  <= '0;
      bitIdx   <= '0;
      frameLen <= '0;
    end else begin
      if (loadShift)     holdFull <= 1'b0;
      else if (acceptWr) holdFull <= 1'b1;

      if (!txEnable) begin
        busy    <= 1'b0;
        tickCnt <= '0;
        bitIdx  <= '0;
      end else if (loadShift) begin
        busy     <= 1'b1;
        tickCnt  <= '0;
        bitIdx   <= '0;
        frameLen <= nextLen;
      end else if (lastTick) begin
        busy    <= 1'b0;
        tickCnt <= '0;
        bitIdx  <= '0;
      end else if (busy && tick) begin
        tickCnt <= bitEnd ? '0 : tickCnt + TICK_W'(1);
        if (bitEnd) bitIdx <= bitIdx + IDX_W'(1);
      end

      if (acceptWr)                   doneFlag <= 1'b0;
      else if (lastTick && !holdFull) doneFlag <= 1'b1;
    end
  end

  assign txEmpty          = !holdFull;
  assign txDone           = doneFlag;
  assign strobe.loadHold  = acceptWr;
  assign strobe.loadShift = loadShift;
  assign strobe.shiftBit  = bitEnd && !lastTick;
  assign strobe.busy      = busy;

  AST_WRITE_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !holdFull) |=> (holdFull && !doneFlag)); // R2
  AST_TRANSFER_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdFull) |-> (busy && bitIdx == '0 && tickCnt == '0)); // R4
  AST_DONE_MEANS_DRAINED: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |-> (!holdFull && !busy)); // R9
  AST_DISABLED_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> !busy); // R10
endmodule

// File: rtl/uart_tx_datapath.sv
module uart_tx_datapath
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wordLong,
  input  logic              parityOn,
  input  logic              parityOdd,
  output logic              txLine
);
  localparam int FRAME_W = DATA_W + 3;

  logic [DATA_W-1:0]  holdReg;
  logic [FRAME_W-1:0] frameReg;
  logic [FRAME_W-1:0] nextFrame;
  logic [DATA_W-1:0]  parMask;
  logic               parBit;
  int                 nBits;

  // Parity covers every sent position below the top one
  always_comb begin
    nBits = wordLong ? DATA_W : DATA_W - 1;
    for (int i = 0; i < DATA_W; i++) parMask[i] = (i < nBits - 1);
    parBit = (^(holdReg & parMask)) ^ parityOdd;
  end

  // Frame: start at bit 0, positions LSB first, stop ones fill above
  always_comb begin
    nextFrame    = '1;
    nextFrame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nBits)
        nextFrame[i+1] = (parityOn && i == nBits - 1) ? parBit : holdReg[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      frameReg <= '1;
    end else begin
      if (strobe.loadHold) holdReg <= wrData;
      if (strobe.loadShift)     frameReg <= nextFrame;
      else if (strobe.shiftBit) frameReg <= {1'b1, frameReg[FRAME_W-1:1]};
    end
  end

  assign txLine = strobe.busy ? frameReg[0] : 1'b1;

  AST_LOAD_STARTS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadShift |=> !txLine); // R5
endmodule

// File: rtl/uart_tx_buffered.sv
module uart_tx_buffered
  import uart_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              enGlobal,
  input  logic              enTx,
  input  logic              wordLong,
  input  logic              parityOn,
  input  logic              parityOdd,
  input  logic [1:0]        stopSel,
  input  logic              txeIrqEn,
  output logic              txLine,
  output logic              txEmpty,
  output logic              txDone,
  output logic              irq
);
  txStrobe_t strobe;
  logic      txEnable;
  logic      stopTwo;

  assign txEnable = enGlobal && enTx;
  assign stopTwo  = (stopSel == 2'b10);

  uart_tx_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .txEnable(txEnable),
    .wordLong(wordLong), .stopTwo(stopTwo), .txEmpty(txEmpty),
    .txDone(txDone), .strobe(strobe)
  );

  uart_tx_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .wordLong(wordLong), .parityOn(parityOn), .parityOdd(parityOdd),
    .txLine(txLine)
  );

  assign irq = txEmpty && txeIrqEn;
endmodule

// File: tb/test_uart_tx_buffered.sv
module test_uart_tx_buffered;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       wrEn = 1'b0;
  logic [8:0] wrData = '0;
  logic       enGlobal = 1'b0, enTx = 1'b0;
  logic       wordLong = 1'b0, parityOn = 1'b0, parityOdd = 1'b0;
  logic [1:0] stopSel = 2'b00;
  logic       txeIrqEn = 1'b1;
  logic       txLine, txEmpty, txDone, irq;

  int checks = 0, errors = 0, cycles = 0;
  int tickPeriod = 1, tdiv = 0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (tdiv >= tickPeriod - 1) begin tdiv = 0; tick = 1'b1; end
    else begin tdiv = tdiv + 1; tick = 1'b0; end
  end

  uart_tx_buffered i_uart_tx_buffered (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .wrData(wrData),
    .enGlobal(enGlobal), .enTx(enTx), .wordLong(wordLong), .parityOn(parityOn),
    .parityOdd(parityOdd), .stopSel(stopSel), .txeIrqEn(txeIrqEn),
    .txLine(txLine), .txEmpty(txEmpty), .txDone(txDone), .irq(irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic expBit(input logic [8:0] d, input bit w9, input bit par,
                                  input bit odd, input int pos);
    int n = w9 ? 9 : 8;
    logic p = odd;
    for (int i = 0; i < n - 1; i++) p ^= d[i];
    if (par && pos == n - 1) return p;
    return d[pos];
  endfunction

  task automatic writeWord(input logic [8:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setCfg(input bit w9, input bit par, input bit odd, input logic [1:0] st);
    wordLong = w9; parityOn = par; parityOdd = odd; stopSel = st;
  endtask

  // Receive one frame and check it; idleAfter: nothing queued behind it
  task automatic verifyFrame(input logic [8:0] d, input string dataTag, input bit idleAfter);
    int n = wordLong ? 9 : 8;
    int s = (stopSel == 2'b10) ? 2 : 1;
    int len = 1 + n + s;
    int guard = 0;
    logic [11:0] bits = '1;
    while (txLine === 1'b1 && guard < 5000) begin @(negedge clk); guard++; end
    check(guard < 5000, "R5 start edge seen", guard, 0);
    repeat (8 * tickPeriod) @(negedge clk);
    bits[0] = txLine;
    for (int b = 1; b < len; b++) begin
      repeat (16 * tickPeriod) @(negedge clk);
      bits[b] = txLine;
    end
    check(bits[0] == 1'b0, "R5 start bit low", bits[0], 0);
    for (int i = 0; i < n; i++) begin
      logic e = expBit(d, wordLong, parityOn, parityOdd, i);
      if (parityOn && i == n - 1)
        check(bits[1+i] == e, "R7 parity bit", bits[1+i], e);
      else
        check(bits[1+i] == e, dataTag, bits[1+i], e);
    end
    for (int k = 0; k < s; k++)
      check(bits[1+n+k] == 1'b1, "R8 stop bit high", bits[1+n+k], 1);
    check(txDone == 1'b0, "R9 done low mid last stop", txDone, 0);
    if (idleAfter) begin
      repeat (16 * tickPeriod) @(negedge clk);
      check(txDone == 1'b1, "R8 R9 done after last stop", txDone, 1);
      check(txLine == 1'b1, "R5 idle high after frame", txLine, 1);
    end
  endtask

  initial begin
    // Reset
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txLine == 1'b1, "R1 line idle", txLine, 1);
    check(txEmpty == 1'b1, "R1 empty flag", txEmpty, 1);
    check(txDone == 1'b1, "R1 done flag", txDone, 1);
    check(irq == 1'b1, "R11 irq with enable", irq, 1);

    // Disabled: word waits, second write ignored
    setCfg(0, 0, 0, 2'b00);
    writeWord(9'h0A5);
    check(txEmpty == 1'b0, "R2 empty cleared", txEmpty, 0);
    check(txDone == 1'b0, "R2 done cleared", txDone, 0);
    check(irq == 1'b0, "R11 irq follows empty", irq, 0);
    writeWord(9'h15A);
    enTx = 1'b1;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      check(txLine == 1'b1, "R10 line high while disabled", txLine, 1);
      check(txEmpty == 1'b0, "R10 word waits", txEmpty, 0);
    end
    txeIrqEn = 1'b0;
    enGlobal = 1'b1;
    @(negedge clk);
    check(txEmpty == 1'b1, "R4 transfer once enabled", txEmpty, 1);
    check(irq == 1'b0, "R11 irq masked", irq, 0);
    verifyFrame(9'h0A5, "R3 R6 held word kept", 1);
    txeIrqEn = 1'b1;

    // Exact cycle timing, 8N1, tick each clock
    writeWord(9'h0C3);
    check(txEmpty == 1'b0, "R2 empty after write", txEmpty, 0);
    check(txDone == 1'b0, "R2 done after write", txDone, 0);
    @(negedge clk);
    check(txEmpty == 1'b1, "R4 empty one edge later", txEmpty, 1);
    check(txLine == 1'b0, "R4 start bit begins", txLine, 0);
    repeat (159) @(negedge clk);
    check(txDone == 1'b0, "R9 done not early", txDone, 0);
    @(negedge clk);
    check(txDone == 1'b1, "R9 done on final edge", txDone, 1);
    check(txLine == 1'b1, "R5 line after frame", txLine, 1);

    // Sweep all formats
    for (int c = 0; c < 32; c++) begin
      for (int j = 0; j < 2; j++) begin
        logic [8:0] d = 9'((c * 73 + j * 341 + 1) & 9'h1FF);
        setCfg(c[0], c[1], c[2], 2'(c >> 3));
        writeWord(d);
        verifyFrame(d, "R6 data bit", 1);
      end
    end

    // Sparse ticks: bit length scales with tick rate
    tickPeriod = 3;
    setCfg(1, 1, 1, 2'b10);
    writeWord(9'h1E7);
    verifyFrame(9'h1E7, "R5 data with sparse tick", 1);
    setCfg(0, 0, 0, 2'b00);
    writeWord(9'h05C);
    verifyFrame(9'h05C, "R5 data with sparse tick", 1);
    tickPeriod = 1;

    // Back-to-back frames
    setCfg(1, 1, 0, 2'b10);
    writeWord(9'h133);
    @(negedge clk);
    check(txEmpty == 1'b1, "R4 first word moved", txEmpty, 1);
    writeWord(9'h0D9);
    check(txEmpty == 1'b0, "R2 second word held", txEmpty, 0);
    verifyFrame(9'h133, "R6 first frame", 0);
    check(txEmpty == 1'b0, "R4 second waits for shifter", txEmpty, 0);
    repeat (9) @(negedge clk);
    check(txEmpty == 1'b1, "R4 reload at frame end", txEmpty, 1);
    check(txLine == 1'b0, "R4 no idle gap", txLine, 0);
    check(txDone == 1'b0, "R9 done held low with word waiting", txDone, 0);
    verifyFrame(9'h0D9, "R6 second frame", 1);

    // Abort mid frame
    setCfg(0, 0, 0, 2'b00);
    writeWord(9'h000);
    repeat (40) @(negedge clk);
    enTx = 1'b0;
    @(negedge clk);
    check(txLine == 1'b1, "R10 abort drives line high", txLine, 1);
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      check(txLine == 1'b1, "R10 stays high after abort", txLine, 1);
    end
    check(txDone == 1'b0, "R9 no done after abort", txDone, 0);
    enTx = 1'b1;
    writeWord(9'h033);
    verifyFrame(9'h033, "R10 frame after abort", 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule